// File: doc/BRIEF.md
# Host Byte Register Loader

This block accepts bytes from a host over an 8-bit bus with two write strobes and turns them into writes to eight 8-bit target registers. One strobe latches a data byte into a holding register. The other latches an address byte into an address register. A target register is written only when two consecutive address writes name the same board and register and the load flag drops from 1 to 0 between them. The write also requires that the board field equal this block's static board identifier, so several boards can share one host bus.

Both strobes are asynchronous to the system clock. Each passes through a two-flop synchronizer and a rising-edge detector, so a strobe held high for many cycles produces exactly one capture. The eight byte registers form four 16-bit output words: three input words and a control word. Each word has a drive enable, and the control word's low and high bytes have separate enables. A disabled byte lane reads as zero on its port; this stands for a pad that is not driving. The register contents are kept while a lane is disabled.

Top module: `hostbyte_loader`

## Requirements
- R1: After reset every target register is zero, so all four output words read 0x0000 with every enable set.
- R2: A rising edge on `data_stb_i` captures `host_bus_i` into the holding register. That value is what a later commit writes.
- R3: Address byte layout: bit 6 is the load flag, bits 5..3 are the board field, bits 2..0 are the target index, and bit 7 is ignored. A commit occurs on an address write whose load flag is 0 when the previous address write had load flag 1 and the same board field and index. For example, 0x46 followed by 0x06 on board 0 writes the low byte of input word 1.
- R4: Index map: 0/1 are the low/high bytes of `word3_o`, 2/3 of `word2_o`, 4/5 of `ctl_o`, and 6/7 of `word1_o`.
- R5: A load-flag fall whose board field differs from `board_id_i` leaves every target register unchanged.
- R6: An address write with no earlier address write since reset commits nothing. A load-flag fall across two writes whose board field or index differ also commits nothing.
- R7: Address write pairs with load flag 0 then 0, or 1 then 1, commit nothing.
- R8: `drive_en_i` bit 0 enables `word1_o`, bit 1 enables `word2_o`, and bit 2 enables `word3_o`. A disabled word reads zero, and its contents reappear when the word is enabled again.
- R9: `drive_en_i` bit 3 enables `ctl_o[7:0]` and bit 4 enables `ctl_o[15:8]`, each independently of the other.
- R10: A strobe held high for several cycles captures once. Bus changes while the strobe stays high do not alter the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_bus_i | input | 8 | Host data bus |
| addr_stb_i | input | 1 | Address write strobe, asynchronous, active on rising edge |
| data_stb_i | input | 1 | Data write strobe, asynchronous, active on rising edge |
| board_id_i | input | 3 | Static board identifier |
| drive_en_i | input | 5 | Per-lane drive enables (see R8, R9) |
| word1_o | output | 16 | Input word 1 |
| word2_o | output | 16 | Input word 2 |
| word3_o | output | 16 | Input word 3 |
| ctl_o | output | 16 | Control word |

## Verification
A wrong address-register or seen-flag state shows at the ports as a missing or spurious byte write. It appears on the relevant output word about three clock cycles after the second address strobe rises. A wrong holding value shows as the wrong byte in the target lane at that same point. A corrupted index decode places the byte in the wrong lane. Bench checks after every host transaction compare all four words, so such a fault is caught at the first transaction that exposes it.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 3;
  localparam int BOARD_W   = 3;
  localparam int NUM_REGS  = 1 << IDX_W;
  localparam int WORD_W    = 2 * BYTE_W;
  localparam int NUM_LANES = 5;

  typedef struct packed {
    logic               spare;
    logic               load;
    logic [BOARD_W-1:0] board;
    logic [IDX_W-1:0]   idx;
  } addr_byte_t;

  // drive-enable lane for each byte register
  function automatic int lane_of(input int idx);
    case (idx)
      0, 1:    lane_of = 2;
      2, 3:    lane_of = 1;
      4:       lane_of = 3;
      5:       lane_of = 4;
      default: lane_of = 0;
    endcase
  endfunction
endpackage

// File: rtl/hbl_reset_sync.sv
module hbl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  always_comb rs_d = {rs_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_n_o = rs_q[STAGES-1];
endmodule

// File: rtl/hbl_strobe_edge.sv
module hbl_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] chain_q;
  logic [SYNC_STAGES:0] chain_d;

  always_comb chain_d = {chain_q[SYNC_STAGES-1:0], strobe_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hbl_addr_ctrl.sv
module hbl_addr_ctrl
  import hbl_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NR = NUM_REGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BW-1:0]      bus_i,
  input  logic               data_rise_i,
  input  logic               addr_rise_i,
  input  logic [BOARD_W-1:0] board_id_i,
  output logic [BW-1:0]      hold_o,
  output logic [NR-1:0]      wr_vec_o
);
  logic [BW-1:0] hold_q, hold_d;
  addr_byte_t    addr_q, addr_d, incoming;
  logic          seen_q, seen_d;
  logic          commit;

  always_comb incoming = addr_byte_t'(bus_i);

  always_comb begin
    hold_d = hold_q;
    addr_d = addr_q;
    seen_d = seen_q;
    if (data_rise_i) hold_d = bus_i;
    if (addr_rise_i) begin
      addr_d = incoming;
      seen_d = 1'b1;
    end
  end

  always_comb begin
    commit = addr_rise_i && seen_q && addr_q.load && !incoming.load &&
             (addr_q.board == incoming.board) && (addr_q.idx == incoming.idx) &&
             (incoming.board == board_id_i);
    wr_vec_o = '0;
    if (commit) wr_vec_o[incoming.idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      addr_q <= '0;
      seen_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      addr_q <= addr_d;
      seen_q <= seen_d;
    end
  end

  assign hold_o = hold_q;

  // R3
  commit_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_vec_o) |-> addr_rise_i);
  // R5
  board_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_rise_i && (bus_i[5:3] != board_id_i)) |-> (wr_vec_o == '0));
  // R6
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (wr_vec_o == '0));
endmodule

// File: rtl/hbl_reg_bank.sv
module hbl_reg_bank
  import hbl_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NR = NUM_REGS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NR-1:0]          wr_vec_i,
  input  logic [BW-1:0]          din_i,
  output logic [NR-1:0][BW-1:0]  regs_o
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic [BW-1:0] r_q, r_d;
    always_comb r_d = wr_vec_i[g] ? din_i : r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
    end
    assign regs_o[g] = r_q;
  end

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vec_i == '0) |=> (regs_o == $past(regs_o)));
  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec_i));
endmodule

// File: rtl/hostbyte_loader.sv
module hostbyte_loader
  import hbl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BYTE_W-1:0]    host_bus_i,
  input  logic                 addr_stb_i,
  input  logic                 data_stb_i,
  input  logic [BOARD_W-1:0]   board_id_i,
  input  logic [NUM_LANES-1:0] drive_en_i,
  output logic [WORD_W-1:0]    word1_o,
  output logic [WORD_W-1:0]    word2_o,
  output logic [WORD_W-1:0]    word3_o,
  output logic [WORD_W-1:0]    ctl_o
);
  logic                             rst_n_int;
  logic                             addr_rise, data_rise;
  logic [BYTE_W-1:0]                hold;
  logic [NUM_REGS-1:0]              wr_vec;
  logic [NUM_REGS-1:0][BYTE_W-1:0]  regs;
  logic [NUM_REGS-1:0][BYTE_W-1:0]  gated;

  hbl_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_int));

  hbl_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_addr_edge (
    .clk(clk), .rst_n(rst_n_int), .strobe_i(addr_stb_i), .rise_o(addr_rise));

  hbl_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_data_edge (
    .clk(clk), .rst_n(rst_n_int), .strobe_i(data_stb_i), .rise_o(data_rise));

  hbl_addr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .bus_i(host_bus_i),
    .data_rise_i(data_rise), .addr_rise_i(addr_rise),
    .board_id_i(board_id_i), .hold_o(hold), .wr_vec_o(wr_vec));

  hbl_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n_int), .wr_vec_i(wr_vec),
    .din_i(hold), .regs_o(regs));

  for (genvar b = 0; b < NUM_REGS; b++) begin : g_lane
    localparam int LANE = lane_of(b);
    assign gated[b] = drive_en_i[LANE] ? regs[b] : '0;
  end

  assign word1_o = {gated[7], gated[6]};
  assign word2_o = {gated[3], gated[2]};
  assign word3_o = {gated[1], gated[0]};
  assign ctl_o   = {gated[5], gated[4]};

  // R9
  ctl_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !drive_en_i[3] |-> (ctl_o[7:0] == '0));
endmodule

// File: tb/hostbyte_loader_tb_top.sv
`timescale 1ns/1ps
module hostbyte_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus;
  logic        astb, dstb;
  logic [2:0]  bid;
  logic [4:0]  en;
  logic [15:0] w1, w2, w3, wc;

  int errors = 0;
  int checks = 0;

  logic [7:0] m_regs [8];
  logic [7:0] m_hold;
  logic [7:0] m_prev;
  logic       m_seen;

  always #2 clk = ~clk;

  hostbyte_loader dut_i (
    .clk(clk), .rst_n(rst_n), .host_bus_i(bus), .addr_stb_i(astb),
    .data_stb_i(dstb), .board_id_i(bid), .drive_en_i(en),
    .word1_o(w1), .word2_o(w2), .word3_o(w3), .ctl_o(wc));

  function automatic logic [7:0] lane(input int i, input int l);
    lane = en[l] ? m_regs[i] : 8'h00;
  endfunction

  task automatic check(input string req);
    logic [15:0] e1, e2, e3, ec;
    e1 = {lane(7, 0), lane(6, 0)};
    e2 = {lane(3, 1), lane(2, 1)};
    e3 = {lane(1, 2), lane(0, 2)};
    ec = {lane(5, 4), lane(4, 3)};
    checks++;
    if (w1 !== e1 || w2 !== e2 || w3 !== e3 || wc !== ec) begin
      errors++;
      $display("FAIL %s: got w1=%h w2=%h w3=%h ctl=%h expected w1=%h w2=%h w3=%h ctl=%h",
               req, w1, w2, w3, wc, e1, e2, e3, ec);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; astb = 1'b0; dstb = 1'b0; bus = 8'h00;
    for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
    m_hold = 8'h00; m_prev = 8'h00; m_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic data_wr(input logic [7:0] v);
    @(negedge clk); bus = v;
    @(negedge clk); dstb = 1'b1;
    repeat (3) @(negedge clk); dstb = 1'b0;
    repeat (3) @(negedge clk);
    m_hold = v;
  endtask

  task automatic addr_wr(input logic [7:0] v);
    @(negedge clk); bus = v;
    @(negedge clk); astb = 1'b1;
    repeat (3) @(negedge clk); astb = 1'b0;
    repeat (3) @(negedge clk);
    if (m_seen && m_prev[6] && !v[6] && (m_prev[5:0] == v[5:0]) && (v[5:3] == bid))
      m_regs[v[2:0]] = m_hold;
    m_prev = v; m_seen = 1'b1;
  endtask

  task automatic load(input logic [2:0] b, input logic [2:0] i, input logic [7:0] v);
    data_wr(v);
    addr_wr({2'b01, b, i});
    addr_wr({2'b00, b, i});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED_1234));
    bid = 3'd0; en = 5'b11111;
    do_reset();
    check("R1 reset zero");

    // R3 worked example: 0x46 then 0x06, board 0
    data_wr(8'hA5);
    addr_wr(8'h46);
    addr_wr(8'h06);
    check("R3 example commit");
    checks++;
    if (w1[7:0] !== 8'hA5) begin
      errors++; $display("FAIL R3: got %h expected a5", w1[7:0]);
    end

    // R4 every index on board 5, bit 7 set to show it is ignored
    bid = 3'd5;
    for (int i = 0; i < 8; i++) begin
      data_wr(8'h10 + 8'(i) * 8'h11);
      addr_wr({2'b11, 3'd5, 3'(i)});
      addr_wr({2'b10, 3'd5, 3'(i)});
    end
    check("R4 index map");
    checks++;
    if (w3 !== 16'h2110 || w2 !== 16'h4332 || wc !== 16'h6554 || w1 !== 16'h8776) begin
      errors++; $display("FAIL R4: got %h %h %h %h expected 8776 4332 2110 6554", w1, w2, w3, wc);
    end

    // R5 mismatched board
    load(3'd2, 3'd6, 8'hEE);
    check("R5 board mismatch");

    // R6 first address write after reset
    do_reset();
    data_wr(8'h5A);
    addr_wr({2'b00, 3'd5, 3'd0});
    check("R6 no prior address");
    // R6 index differs across the pair
    addr_wr({2'b01, 3'd5, 3'd1});
    addr_wr({2'b00, 3'd5, 3'd2});
    check("R6 index change");
    // R2 hold value used
    load(3'd5, 3'd2, 8'h3C);
    check("R2 hold captured");

    // R7 load 0->0 and 1->1
    data_wr(8'hC3);
    addr_wr({2'b00, 3'd5, 3'd3});
    addr_wr({2'b00, 3'd5, 3'd3});
    check("R7 zero-zero");
    addr_wr({2'b01, 3'd5, 3'd3});
    addr_wr({2'b01, 3'd5, 3'd3});
    check("R7 one-one");

    // R8 word enables
    load(3'd5, 3'd6, 8'h77);
    load(3'd5, 3'd0, 8'h99);
    en = 5'b11010; #1;
    check("R8 words disabled");
    en = 5'b11111; #1;
    check("R8 contents retained");

    // R9 ctl halves
    load(3'd5, 3'd4, 8'h12);
    load(3'd5, 3'd5, 8'h34);
    en = 5'b10111; #1;
    check("R9 ctl low off");
    en = 5'b01111; #1;
    check("R9 ctl high off");
    en = 5'b11111; #1;

    // R10 long strobe, bus changes while high
    @(negedge clk); bus = 8'h61;
    @(negedge clk); dstb = 1'b1;
    repeat (3) @(negedge clk); bus = 8'hF0;
    repeat (5) @(negedge clk); dstb = 1'b0;
    repeat (3) @(negedge clk);
    m_hold = 8'h61;
    addr_wr({2'b01, 3'd5, 3'd7});
    addr_wr({2'b00, 3'd5, 3'd7});
    check("R10 single capture");

    // random mix (R3 R5 R6 R7)
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      r = 8'($urandom());
      if (k < 3) data_wr(r);
      else if (k < 6) begin
        if ($urandom_range(0, 3) != 0) r[5:3] = bid;
        addr_wr(r);
      end else begin
        r = m_prev;
        r[6] = 1'b0;
        if ($urandom_range(0, 4) == 0) r[5:3] = 3'($urandom());
        addr_wr(r);
      end
      if ((n % 40) == 0) en = 5'($urandom());
      if ((n % 40) == 20) en = 5'b11111;
      #1;
      check("R3 random sequence");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule